// File: doc/BRIEF.md
# Single-Shot Video Frame Capture Controller

This block grabs one grayscale frame from an 8-bit parallel video converter and stores it in a frame buffer RAM that sits beside it. A host processor runs it as a slave. The host issues a start command, and the block then waits for the next rising edge of vertical sync. From there it follows horizontal sync and a pixel-clock enable. It writes the samples of a fixed active window in raster order, driving the buffer address, chip select, write strobe and write data. It also drives a conversion strobe to the converter. Once the final pixel of the window is written, it raises an interrupt.

Next comes readback. The host pulls the frame out one byte per read strobe. The block supplies the buffer address and returns the buffer's read data on the host port. After the last byte, the read pointer wraps to zero and a done flag comes up. The block then sits idle until the next start. Video never streams continuously: every frame needs its own start.

All inputs are synchronous to `clk`. Both sync inputs are active high and act on their rising edges. `pixEn` marks each pixel-clock slot. The buffer RAM is expected to return read data in the same cycle as the address.

Top module: `frame_capture`

## Requirements
- R1: While `rst` is high and in the cycle after it is released, `irq`, `rdDone`, `bufWe`, `bufCs` and `adcConv` are all 0.
- R2: With no start accepted, nothing is written to the buffer. After an accepted start, the block writes nothing until a rising edge of `vSync`.
- R3: Count lines from 0 at the first rising edge of `hSync` after the `vSync` edge. Count `pixEn` cycles from 0 after each `hSync` edge. Pixel P of line L is written when P is in H_OFF to H_OFF+ACT_W-1 and L is in V_OFF to V_OFF+ACT_H-1. It goes to address (L-V_OFF)*ACT_W+(P-H_OFF), with `bufWe`=1 and `bufCs`=1 in the cycle after the sampled `pixEn`, carrying the `adcData` of that cycle.
- R4: `irq` rises in the cycle right after the write strobe of address ACT_W*ACT_H-1. No write strobe occurs while `irq` is high, and no further pixels of that frame are stored.
- R5: Once raised, `irq` stays high until `irqAck` is high in a cycle or the first readback strobe `hostRd` is accepted. It is 0 from the following cycle.
- R6: During readback, a cycle with `hostRd`=1 drives `bufCs`=1 and `bufWe`=0. It drives `bufAddr` with the read pointer and `hostRdData` with `bufRdData` in that same cycle. The read pointer starts at 0 and advances by one per accepted strobe.
- R7: The strobe that reads address ACT_W*ACT_H-1 wraps the pointer to 0 and sets `rdDone` from the next cycle. After that, `hostRd` is ignored (`bufCs` stays 0) until a new start.
- R8: A `start` while the block is waiting for vertical sync, capturing or reading back has no effect. The capture continues and the readback completes at the same addresses.
- R9: A rising edge of `vSync` during capture, before the frame is complete, restarts the capture: lines and the write address count again from 0.
- R10: `adcConv` equals the previous cycle's `pixEn` from the cycle after an accepted start through the cycle that samples the last stored pixel. Outside that span it is 0.
- R11: An accepted `start` clears `rdDone` from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Host start command, accepted only when idle |
| irqAck | input | 1 | Host acknowledge that clears the interrupt |
| irq | output | 1 | Frame-complete interrupt request |
| rdDone | output | 1 | Set after the whole frame was read back |
| hSync | input | 1 | Horizontal sync, rising edge starts a line |
| vSync | input | 1 | Vertical sync, rising edge starts a frame |
| pixEn | input | 1 | Pixel-clock slot enable |
| adcData | input | DATA_W | Converter sample for the current pixel slot |
| adcConv | output | 1 | Conversion strobe to the converter |
| bufAddr | output | ADDR_W | Frame buffer address |
| bufCs | output | 1 | Frame buffer chip select |
| bufWe | output | 1 | Frame buffer write strobe |
| bufWrData | output | DATA_W | Frame buffer write data |
| bufRdData | input | DATA_W | Frame buffer read data, same-cycle |
| hostRd | input | 1 | Host read strobe, one byte per cycle it is high |
| hostRdData | output | DATA_W | Byte returned to the host |

## Verification
The bench builds the block with an 8 by 4 active window, a horizontal offset of 2 and a vertical offset of 1, so a whole frame is 32 pixels. The last-address interrupt, the pointer wrap, the window edges on both axes and a mid-frame vertical-sync restart each take only a few hundred cycles. One frame uses exactly 5 lines of 10 pixels, the smallest timing that fills the buffer. Others add lines and pixels beyond the window, and random gaps between pixel slots and between reads.

// File: rtl/frame_cap_pkg.sv
package frame_cap_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_CAPT,
    ST_FLUSH,
    ST_READ
  } capState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armed;     // waiting for vertical sync, converter running
    logic capRun;    // window samples may be stored
    logic capClear;  // restart line, pixel and write counters
    logic rdRun;     // readback strobes are served
  } capCtl_t;

  // events from datapath to control
  typedef struct packed {
    logic vsRise;    // rising edge of vertical sync
    logic frameFull; // the sample for the last address is being stored
    logic rdFire;    // a readback strobe is served this cycle
    logic lastRead;  // that strobe reads the last address
  } capStat_t;

endpackage

// File: rtl/frame_cap_ctrl.sv
module frame_cap_ctrl
  import frame_cap_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     start,
  input  logic     irqAck,
  input  capStat_t stat,
  output capCtl_t  ctl,
  output logic     irq,
  output logic     rdDone
);

  capState_e state;
  capState_e stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (start)          stateNext = ST_ARM;
      ST_ARM:   if (stat.vsRise)    stateNext = ST_CAPT;
      ST_CAPT:  if (stat.frameFull) stateNext = ST_FLUSH;
      ST_FLUSH:                     stateNext = ST_READ;
      ST_READ:  if (stat.lastRead)  stateNext = ST_IDLE;
      default:                      stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    ctl.armed    = (state == ST_ARM);
    ctl.capRun   = (state == ST_CAPT);
    ctl.capClear = ((state == ST_ARM) || (state == ST_CAPT)) && stat.vsRise;
    ctl.rdRun    = (state == ST_READ);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      irq    <= 1'b0;
      rdDone <= 1'b0;
    end else begin
      state <= stateNext;

      // interrupt comes up after the final write has left the pipeline
      if (state == ST_FLUSH) begin
        irq <= 1'b1;
      end else if (irqAck || stat.rdFire) begin
        irq <= 1'b0;
      end

      if ((state == ST_IDLE) && start) begin
        rdDone <= 1'b0;
      end else if (stat.lastRead) begin
        rdDone <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/frame_cap_dpath.sv
module frame_cap_dpath
  import frame_cap_pkg::*;
#(
  parameter int ACT_W  = 512,
  parameter int ACT_H  = 512,
  parameter int H_OFF  = 16,
  parameter int V_OFF  = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  capCtl_t           ctl,
  output capStat_t          stat,
  input  logic              hSync,
  input  logic              vSync,
  input  logic              pixEn,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcConv,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufCs,
  output logic              bufWe,
  output logic [DATA_W-1:0] bufWrData,
  input  logic [DATA_W-1:0] bufRdData,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData
);

  localparam int PIX_N  = ACT_W * ACT_H;
  localparam int PC_END = H_OFF + ACT_W;          // first column past the window
  localparam int PC_W   = $clog2(PC_END + 1);
  localparam int LC_END = V_OFF + ACT_H;          // line count of the last stored line
  localparam int LC_W   = $clog2(LC_END + 2);

  localparam logic [PC_W-1:0]   COL_LO   = PC_W'(H_OFF);
  localparam logic [PC_W-1:0]   COL_SAT  = PC_W'(PC_END);
  localparam logic [LC_W-1:0]   ROW_LO   = LC_W'(V_OFF + 1);
  localparam logic [LC_W-1:0]   ROW_HI   = LC_W'(LC_END);
  localparam logic [LC_W-1:0]   ROW_SAT  = LC_W'(LC_END + 1);
  localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(PIX_N - 1);

  // sync edge detection
  logic hPrev;
  logic vPrev;
  logic hRise;
  logic vRise;

  assign hRise = hSync && !hPrev;
  assign vRise = vSync && !vPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hPrev <= 1'b0;
      vPrev <= 1'b0;
    end else begin
      hPrev <= hSync;
      vPrev <= vSync;
    end
  end

  // window tracking: lineCnt counts hsync edges since vsync, so line index is lineCnt-1
  logic [PC_W-1:0]   pixCnt;
  logic [LC_W-1:0]   lineCnt;
  logic [ADDR_W-1:0] wrPtr;
  logic              inCol;
  logic              inRow;
  logic              storeEv;

  assign inCol   = (pixCnt >= COL_LO) && (pixCnt < COL_SAT);
  assign inRow   = (lineCnt >= ROW_LO) && (lineCnt <= ROW_HI);
  assign storeEv = ctl.capRun && pixEn && !hRise && !vRise && inCol && inRow;

  always_ff @(posedge clk) begin
    if (rst || ctl.capClear) begin
      pixCnt  <= COL_SAT;
      lineCnt <= '0;
      wrPtr   <= '0;
    end else if (ctl.capRun) begin
      if (hRise) begin
        pixCnt <= '0;
        if (lineCnt != ROW_SAT) begin
          lineCnt <= lineCnt + 1'b1;
        end
      end else if (pixEn) begin
        if (pixCnt != COL_SAT) begin
          pixCnt <= pixCnt + 1'b1;
        end
      end
      if (storeEv) begin
        wrPtr <= wrPtr + 1'b1;
      end
    end
  end

  // one-cycle registered write stage toward the buffer
  logic              wrValid;
  logic [ADDR_W-1:0] wrAddrQ;
  logic [DATA_W-1:0] wrDataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrValid <= 1'b0;
      wrAddrQ <= '0;
      wrDataQ <= '0;
      adcConv <= 1'b0;
    end else begin
      wrValid <= storeEv;
      if (storeEv) begin
        wrAddrQ <= wrPtr;
        wrDataQ <= adcData;
      end
      adcConv <= pixEn && (ctl.armed || ctl.capRun);
    end
  end

  // readback pointer
  logic [ADDR_W-1:0] rdPtr;
  logic              rdFire;
  logic              rdLast;

  assign rdFire = ctl.rdRun && hostRd;
  assign rdLast = rdFire && (rdPtr == ADDR_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr <= '0;
    end else if (rdFire) begin
      rdPtr <= rdLast ? '0 : rdPtr + 1'b1;
    end
  end

  // buffer port: a pending write owns the address
  assign bufWe      = wrValid;
  assign bufCs      = wrValid || rdFire;
  assign bufAddr    = wrValid ? wrAddrQ : rdPtr;
  assign bufWrData  = wrDataQ;
  assign hostRdData = rdFire ? bufRdData : '0;

  always_comb begin
    stat.vsRise    = vRise;
    stat.frameFull = storeEv && (wrPtr == ADDR_END);
    stat.rdFire    = rdFire;
    stat.lastRead  = rdLast;
  end

endmodule

// File: rtl/frame_capture.sv
module frame_capture
  import frame_cap_pkg::*;
#(
  parameter int ACT_W  = 512,
  parameter int ACT_H  = 512,
  parameter int H_OFF  = 16,
  parameter int V_OFF  = 8,
  parameter int DATA_W = 8,
  localparam int ADDR_W = $clog2(ACT_W * ACT_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              irqAck,
  output logic              irq,
  output logic              rdDone,
  input  logic              hSync,
  input  logic              vSync,
  input  logic              pixEn,
  input  logic [DATA_W-1:0] adcData,
  output logic              adcConv,
  output logic [ADDR_W-1:0] bufAddr,
  output logic              bufCs,
  output logic              bufWe,
  output logic [DATA_W-1:0] bufWrData,
  input  logic [DATA_W-1:0] bufRdData,
  input  logic              hostRd,
  output logic [DATA_W-1:0] hostRdData
);

  capCtl_t  ctl;
  capStat_t stat;

  frame_cap_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .irqAck (irqAck),
    .stat   (stat),
    .ctl    (ctl),
    .irq    (irq),
    .rdDone (rdDone)
  );

  frame_cap_dpath #(
    .ACT_W  (ACT_W),
    .ACT_H  (ACT_H),
    .H_OFF  (H_OFF),
    .V_OFF  (V_OFF),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_dpath (
    .clk        (clk),
    .rst        (rst),
    .ctl        (ctl),
    .stat       (stat),
    .hSync      (hSync),
    .vSync      (vSync),
    .pixEn      (pixEn),
    .adcData    (adcData),
    .adcConv    (adcConv),
    .bufAddr    (bufAddr),
    .bufCs      (bufCs),
    .bufWe      (bufWe),
    .bufWrData  (bufWrData),
    .bufRdData  (bufRdData),
    .hostRd     (hostRd),
    .hostRdData (hostRdData)
  );

endmodule

// File: rtl/frame_capture_chk.sv
module frame_capture_chk (
  input logic clk,
  input logic rst,
  input logic irq,
  input logic irqAck,
  input logic hostRd,
  input logic rdDone,
  input logic bufWe,
  input logic bufCs,
  input logic adcConv
);

  // a write strobe always carries chip select
  assert_we_cs_R3: assert property (@(posedge clk) disable iff (rst)
    bufWe |-> bufCs);

  // no buffer write while the interrupt is pending
  assert_no_write_irq_R4: assert property (@(posedge clk) disable iff (rst)
    irq |-> !bufWe);

  // interrupt follows the final write strobe
  assert_irq_after_write_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(bufWe));

  // interrupt holds until acknowledged or read
  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (irq && !irqAck && !hostRd) |=> irq);

  // a select without write comes only from a host read
  assert_rd_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    (bufCs && !bufWe) |-> hostRd);

  // done flag rises only after a read strobe
  assert_done_after_read_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rdDone) |-> $past(hostRd));

  // converter quiet while the finished frame waits
  assert_adc_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    rdDone |-> !adcConv);

endmodule

bind frame_capture frame_capture_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .irq     (irq),
  .irqAck  (irqAck),
  .hostRd  (hostRd),
  .rdDone  (rdDone),
  .bufWe   (bufWe),
  .bufCs   (bufCs),
  .adcConv (adcConv)
);

// File: tb/frame_capture_tb.sv
module frame_capture_tb;

  localparam int W  = 8;
  localparam int H  = 4;
  localparam int HO = 2;
  localparam int VO = 1;
  localparam int N  = W * H;
  localparam int AW = $clog2(N);
  localparam int WATCHDOG = 100000;

  logic          clk = 1'b0;
  logic          rst;
  logic          start, irqAck, hSync, vSync, pixEn, hostRd;
  logic [7:0]    adcData;
  logic          irq, rdDone, adcConv, bufCs, bufWe;
  logic [AW-1:0] bufAddr;
  logic [7:0]    bufWrData, bufRdData, hostRdData;

  always #10 clk = ~clk;  // 50 MHz

  frame_capture #(
    .ACT_W(W), .ACT_H(H), .H_OFF(HO), .V_OFF(VO), .DATA_W(8)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .irqAck(irqAck), .irq(irq), .rdDone(rdDone),
    .hSync(hSync), .vSync(vSync), .pixEn(pixEn), .adcData(adcData), .adcConv(adcConv),
    .bufAddr(bufAddr), .bufCs(bufCs), .bufWe(bufWe), .bufWrData(bufWrData),
    .bufRdData(bufRdData), .hostRd(hostRd), .hostRdData(hostRdData)
  );

  // frame buffer model: synchronous write, same-cycle read
  logic [7:0] mem [N];
  always @(posedge clk) if (bufWe === 1'b1) mem[bufAddr] <= bufWrData;
  assign bufRdData = mem[bufAddr];

  int checks = 0;
  int failures = 0;
  int cycCnt = 0;

  // behaviour model state, built from the requirements
  int capState = 0;  // 0 idle, 1 armed, 2 capturing, 3 frame stored
  int lineNum = -1;
  int pixNum = 1000;
  int wrCount = 0;
  bit adcOn = 0;
  bit irqDue = 0;
  bit restarted = 0;
  logic [7:0] expData [N];

  always @(posedge clk) begin
    cycCnt++;
    if (cycCnt == WATCHDOG) begin
      failures++;
      $display("FAIL watchdog all-requirements actual=%0d expected<%0d", cycCnt, WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one video cycle with model update and output checks
  task automatic vidCycle(input bit h, input bit v, input bit p, input bit st);
    logic [7:0] d;
    bit expWe;
    int expAddr;
    bit expAdc;
    bit chkIrq;
    bit wasLast;
    bit accepted;
    d = 8'($urandom);
    hSync = h; vSync = v; pixEn = p; adcData = d; start = st;
    expWe = 0; expAddr = 0;
    expAdc = p && adcOn;
    chkIrq = irqDue; irqDue = 0;
    accepted = st && (capState == 0);
    if (capState == 2) begin
      if (v) begin
        lineNum = -1; pixNum = 1000; wrCount = 0; restarted = 1;
      end else if (h) begin
        lineNum++; pixNum = 0;
      end else if (p) begin
        if (lineNum >= VO && lineNum < VO + H && pixNum >= HO && pixNum < HO + W) begin
          expWe = 1; expAddr = wrCount; expData[wrCount] = d; wrCount++;
        end
        pixNum++;
      end
    end else if (capState == 1 && v) begin
      capState = 2; lineNum = -1; pixNum = 1000; wrCount = 0;
    end
    wasLast = expWe && (wrCount == N);
    step();
    start = 1'b0;
    if (expWe || bufWe === 1'b1) begin
      check(bufWe === 1'b1 && expWe && int'(bufAddr) == expAddr && bufCs === 1'b1,
            restarted ? "R9" : "R3", "write strobe/address", int'(bufAddr), expAddr);
      if (expWe)
        check(bufWrData === expData[expAddr], restarted ? "R9" : "R3", "write data",
              int'(bufWrData), int'(expData[expAddr]));
    end
    if (p || adcConv === 1'b1)
      check(adcConv === expAdc, "R10", "converter strobe", int'(adcConv), int'(expAdc));
    if (chkIrq) check(irq === 1'b1, "R4", "irq after last write", int'(irq), 1);
    if (wasLast) begin
      check(irq === 1'b0, "R4", "irq not early", int'(irq), 0);
      capState = 3; adcOn = 0; irqDue = 1;
    end
    if (accepted) begin
      check(rdDone === 1'b0, "R11", "done cleared on start", int'(rdDone), 0);
      capState = 1; adcOn = 1; restarted = 0;
    end
  endtask

  task automatic sendFrame(input int lines, input int pixPerLine, input int startLine);
    vidCycle(0, 1, 0, 0);
    for (int i = 0; i < 3; i++) vidCycle(0, 0, 0, 0);
    for (int ln = 0; ln < lines; ln++) begin
      vidCycle(1, 0, 0, ln == startLine);
      for (int k = 0; k < pixPerLine; k++) begin
        if ($urandom % 3 == 0) vidCycle(0, 0, 0, 0);
        vidCycle(0, 0, 1, 0);
      end
      vidCycle(0, 0, 0, 0);
    end
    vidCycle(0, 0, 0, 0);
  endtask

  task automatic readAll(input int midStart);
    for (int i = 0; i < N; i++) begin
      if ($urandom % 2 == 1) step();
      if (i == midStart) begin
        start = 1'b1;           // R8: ignored during readback
        step();
        start = 1'b0;
      end
      hostRd = 1'b1;
      #1;
      check(bufCs === 1'b1 && bufWe === 1'b0, "R6", "read select", int'(bufCs), 1);
      check(int'(bufAddr) == i, "R6", "read address", int'(bufAddr), i);
      check(hostRdData === expData[i], "R6", "read data", int'(hostRdData), int'(expData[i]));
      step();
      hostRd = 1'b0;
      if (i == 0) check(irq === 1'b0, "R5", "irq cleared by first read", int'(irq), 0);
      if (i == N - 2) check(rdDone === 1'b0, "R7", "done not early", int'(rdDone), 0);
    end
    check(rdDone === 1'b1, "R7", "done after last read", int'(rdDone), 1);
    hostRd = 1'b1;
    #1;
    check(bufCs === 1'b0, "R7", "read ignored after done", int'(bufCs), 0);
    step();
    hostRd = 1'b0;
    capState = 0;
  endtask

  initial begin
    void'($urandom(32'd24681));
    rst = 1'b1; start = 0; irqAck = 0; hSync = 0; vSync = 0; pixEn = 0;
    hostRd = 0; adcData = '0;
    repeat (3) step();
    check(irq === 1'b0 && rdDone === 1'b0, "R1", "flags in reset", int'(irq) + int'(rdDone), 0);
    check(bufWe === 1'b0 && bufCs === 1'b0 && adcConv === 1'b0, "R1", "strobes in reset",
          int'(bufWe) + int'(bufCs) + int'(adcConv), 0);
    rst = 1'b0;
    step();
    check(irq === 1'b0 && bufCs === 1'b0, "R1", "idle after release", int'(irq) + int'(bufCs), 0);

    // R2: video without a start is not captured
    sendFrame(6, 13, -1);
    check(irq === 1'b0, "R2", "no interrupt without start", int'(irq), 0);

    // R2/R10: start, then pixels before vertical sync are not stored
    vidCycle(0, 0, 0, 1);
    for (int i = 0; i < 3; i++) vidCycle(0, 0, 1, 0);
    // R8: start mid-capture at line 2 is ignored
    sendFrame(6, 13, 2);
    for (int i = 0; i < 5; i++) vidCycle(0, 0, 0, 0);
    check(irq === 1'b1, "R5", "irq held while waiting", int'(irq), 1);
    readAll(5);

    // R11 and R9: new capture, partial frame cut by a fresh vertical sync
    vidCycle(0, 0, 0, 1);
    sendFrame(3, 13, -1);
    sendFrame(7, 12, -1);
    for (int i = 0; i < 3; i++) vidCycle(0, 0, 0, 0);
    check(irq === 1'b1, "R5", "irq held before ack", int'(irq), 1);
    irqAck = 1'b1;
    step();
    irqAck = 1'b0;
    check(irq === 1'b0, "R5", "irq cleared by ack", int'(irq), 0);
    readAll(-1);

    // smallest timing that fills the window exactly
    vidCycle(0, 0, 0, 1);
    sendFrame(5, 10, -1);
    check(capState == 3, "R4", "frame filled at boundary", capState, 3);
    readAll(-1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule